// File: doc/BRIEF.md
# Cycle Counter and Data Watchpoint Unit

This unit sits beside a processor core and observes it without disturbing it. It keeps a 32-bit count of core clock cycles and five 8-bit counters. Each 8-bit counter tallies cycles on which one core-supplied event strobe is high. The unit also holds a small set of address comparators that watch the core's data bus. Each comparator can cover one address or a naturally aligned power-of-two region. Each can trigger on reads, on writes or on both. On a match it either raises a halt request towards the debug logic or emits a per-comparator trace event, and it records the hit in a sticky flag.

A debugger or monitor firmware reaches everything through a simple word-addressed register bus with fixed byte offsets. Read data is returned combinationally in the same cycle as the read strobe. A read-only offset returns the live program counter input, which supports statistical profiling. A single global trace-enable input gates all counting and all matching. When it is low the unit is inert, while its registers can still be read and written.

Top module: `cycwatch_top`

## Requirements
- R1: After reset the control word, the cycle counter, all five event counters and every comparator register (address, mask, function, sticky flag) read 0, and `halt_req`, `watch_evt` and `ovf_evt` are low.
- R2: Offset 0x000 is the control word, and bit 0 enables the cycle counter. The counter at offset 0x004 advances by exactly 1 on every clock edge while bit 0 and `trace_en` are both 1, holds otherwise, and takes the written value when written (a write beats an increment).
- R3: The cycle counter wraps from 0xFFFFFFFF to 0x00000000.
- R4: The 8-bit event counters sit at offsets 0x008, 0x00C, 0x010, 0x014 and 0x018, driven by `ev_in[0]` to `ev_in[4]` in that order. Each advances by 1 on every clock edge where its strobe and `trace_en` are high. Each is writable and reads back zero-extended.
- R5: An event counter wraps from 0xFF to 0x00. Its `ovf_evt` bit is high for exactly the one cycle after the wrapping edge, while the counter reads 0.
- R6: A read of offset 0x01C returns `pc_in` in the same cycle, and writes to it are ignored.
- R7: Comparator n has its address register at 0x020+16n, its mask register at 0x024+16n (bits 4:0) and its function register at 0x028+16n.
- R8: A mask value M makes the comparator ignore the low M address bits, so it matches any bus address inside the 2^M-byte aligned block that contains its address register.
- R9: Function bits 3:0 select the access kind: 0 = off, 5 = reads only, 6 = writes only, 7 = reads and writes. Any other code never matches.
- R10: With function bit 4 = 0, a match drives `halt_req` high in the same cycle as the bus access. With bit 4 = 1, the same match drives that comparator's `watch_evt` bit instead and leaves `halt_req` low.
- R11: A match sets a sticky flag seen at function-register bit 24. A read of the function register returns the flag and clears it, unless a new match occurs in that same cycle.
- R12: While `trace_en` is low, no counter changes except by a register write, and no comparator matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trace_en | input | 1 | Global gate for counting and matching |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears sticky flags) |
| reg_addr | input | 12 | Byte offset of the register access |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, same cycle |
| pc_in | input | 32 | Current program counter of the core |
| ev_in | input | 5 | Event strobes for the five event counters |
| bus_valid | input | 1 | Data bus access in this cycle |
| bus_write | input | 1 | Access is a write (1) or read (0) |
| bus_addr | input | 32 | Data bus byte address |
| halt_req | output | 1 | Debug halt request from any halting comparator |
| watch_evt | output | 4 | Per-comparator trace event pulse |
| ovf_evt | output | 5 | Per-event-counter wrap pulse |

## Verification
A corrupted comparator address, mask or function code shows at once on `halt_req` or `watch_evt` during the next bus access that hits or misses the region. The bench drives many random accesses near each configured region, so a wrong care mask or kind decode is exposed within a few accesses. A counter that skips, double-counts or ignores the gate shows in the read value after a gate window of known length, and a wrong wrap shows on `ovf_evt` in the single cycle after the wrapping edge. A sticky flag that fails to set or clear shows on the next read of the function register.

// File: rtl/wm_pkg.sv
`timescale 1ns/1ps
package wm_pkg;
    localparam int unsigned NUM_EVT = 5;

    localparam logic [11:0] OFF_CTRL = 12'h000;
    localparam logic [11:0] OFF_CYC  = 12'h004;
    localparam int unsigned OFF_EVT0 = 8;
    localparam logic [11:0] OFF_PC   = 12'h01C;
    localparam int unsigned OFF_CMP0 = 32;
    localparam int unsigned CMP_STRIDE = 16;

    localparam logic [3:0] KIND_OFF = 4'd0;
    localparam logic [3:0] KIND_RD  = 4'd5;
    localparam logic [3:0] KIND_WR  = 4'd6;
    localparam logic [3:0] KIND_ANY = 4'd7;

    localparam int unsigned FN_ACT_BIT    = 4;
    localparam int unsigned FN_STICKY_BIT = 24;

    function automatic logic kind_match(input logic [3:0] kind, input logic is_wr);
        logic ok;
        case (kind)
            KIND_RD:  ok = !is_wr;
            KIND_WR:  ok = is_wr;
            KIND_ANY: ok = 1'b1;
            default:  ok = 1'b0;
        endcase
        return ok;
    endfunction
endpackage

// File: rtl/wm_cyc_ctr.sv
`timescale 1ns/1ps
module wm_cyc_ctr #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         wr_en,
    input  logic [W-1:0] wr_val,
    output logic [W-1:0] cnt
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } cyc_st_t;

    cyc_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en)
            st_d.cnt = wr_val;
        else if (run)
            st_d.cnt = st_q.cnt + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;

    // R2
    cyc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !wr_en) |=> (cnt == $past(cnt) + W'(1)));
    // R3
    cyc_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !wr_en && cnt == '1) |=> (cnt == '0));
    // R12
    cyc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !wr_en) |=> $stable(cnt));
endmodule

// File: rtl/wm_evt_ctr.sv
`timescale 1ns/1ps
module wm_evt_ctr #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         wr_en,
    input  logic [W-1:0] wr_val,
    output logic [W-1:0] cnt,
    output logic         ovf
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic         ovf;
    } evt_st_t;

    evt_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.ovf = 1'b0;
        if (wr_en)
            st_d.cnt = wr_val;
        else if (tick)
            {st_d.ovf, st_d.cnt} = {1'b0, st_q.cnt} + (W+1)'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;
    assign ovf = st_q.ovf;

    // R4
    evt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_en) |=> (cnt == $past(cnt) + W'(1)));
    // R5
    evt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_en && cnt == '1) |=> (ovf && cnt == '0));
    // R12
    evt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_en) |=> ($stable(cnt) && !ovf));
endmodule

// File: rtl/wm_cmp.sv
`timescale 1ns/1ps
module wm_cmp
    import wm_pkg::*;
#(
    parameter int unsigned AW = 32,
    parameter int unsigned MW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          gate,
    input  logic          bus_valid,
    input  logic          bus_write,
    input  logic [AW-1:0] bus_addr,
    input  logic          set_addr,
    input  logic          set_mask,
    input  logic          set_func,
    input  logic [AW-1:0] wval_addr,
    input  logic [MW-1:0] wval_mask,
    input  logic [4:0]    wval_func,
    input  logic          rd_func,
    output logic [AW-1:0] addr_o,
    output logic [MW-1:0] mask_o,
    output logic [3:0]    kind_o,
    output logic          act_o,
    output logic          sticky_o,
    output logic          hit_halt,
    output logic          hit_evt
);
    typedef struct packed {
        logic [AW-1:0] addr;
        logic [MW-1:0] mask;
        logic [3:0]    kind;
        logic          act;
        logic          sticky;
    } cmp_st_t;

    cmp_st_t       st_d, st_q;
    logic [AW-1:0] care;
    logic          hit;

    always_comb begin
        care = {AW{1'b1}} << st_q.mask;
        hit  = gate && bus_valid && kind_match(st_q.kind, bus_write)
               && (((bus_addr ^ st_q.addr) & care) == '0);

        st_d = st_q;
        if (set_addr) st_d.addr = wval_addr;
        if (set_mask) st_d.mask = wval_mask;
        if (set_func) begin
            st_d.kind = wval_func[3:0];
            st_d.act  = wval_func[FN_ACT_BIT];
        end
        if (hit)
            st_d.sticky = 1'b1;
        else if (rd_func)
            st_d.sticky = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign addr_o   = st_q.addr;
    assign mask_o   = st_q.mask;
    assign kind_o   = st_q.kind;
    assign act_o    = st_q.act;
    assign sticky_o = st_q.sticky;
    assign hit_halt = hit && !st_q.act;
    assign hit_evt  = hit && st_q.act;

    // R11
    sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_halt || hit_evt) |=> sticky_o);
    // R11
    sticky_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_func && !hit_halt && !hit_evt) |=> !sticky_o);
    // R12
    gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gate |-> !(hit_halt || hit_evt));
    // R9
    kind_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_o == KIND_OFF) |-> !(hit_halt || hit_evt));
endmodule

// File: rtl/cycwatch_top.sv
`timescale 1ns/1ps
module cycwatch_top
    import wm_pkg::*;
#(
    parameter int unsigned NUM_CMP = 4,
    parameter int unsigned CYC_W   = 32,
    parameter int unsigned EVT_W   = 8,
    parameter int unsigned AW      = 32,
    parameter int unsigned MASK_W  = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               trace_en,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [11:0]        reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic [31:0]        pc_in,
    input  logic [NUM_EVT-1:0] ev_in,
    input  logic               bus_valid,
    input  logic               bus_write,
    input  logic [AW-1:0]      bus_addr,
    output logic               halt_req,
    output logic [NUM_CMP-1:0] watch_evt,
    output logic [NUM_EVT-1:0] ovf_evt
);
    localparam int unsigned CMP_END = OFF_CMP0 + CMP_STRIDE * NUM_CMP;

    typedef struct packed {
        logic cyc_on;
    } ctrl_st_t;

    ctrl_st_t ctrl_d, ctrl_q;

    logic               cyc_wr;
    logic [CYC_W-1:0]   cyc_cnt;
    logic [NUM_EVT-1:0] evt_wr;
    logic [EVT_W-1:0]   evt_cnt [NUM_EVT];
    logic [NUM_CMP-1:0] cmp_set_addr, cmp_set_mask, cmp_set_func, cmp_rd_func;
    logic [AW-1:0]      cmp_addr   [NUM_CMP];
    logic [MASK_W-1:0]  cmp_mask   [NUM_CMP];
    logic [3:0]         cmp_kind   [NUM_CMP];
    logic [NUM_CMP-1:0] cmp_act, cmp_sticky, cmp_halt, cmp_evt;

    // decode and control next state
    always_comb begin
        ctrl_d = ctrl_q;
        if (reg_wr && reg_addr == OFF_CTRL)
            ctrl_d.cyc_on = reg_wdata[0];
        cyc_wr = reg_wr && (reg_addr == OFF_CYC);
        for (int i = 0; i < NUM_EVT; i++)
            evt_wr[i] = reg_wr && (reg_addr == 12'(OFF_EVT0 + 4*i));
        for (int i = 0; i < NUM_CMP; i++) begin
            cmp_set_addr[i] = reg_wr && (reg_addr == 12'(OFF_CMP0 + CMP_STRIDE*i));
            cmp_set_mask[i] = reg_wr && (reg_addr == 12'(OFF_CMP0 + CMP_STRIDE*i + 4));
            cmp_set_func[i] = reg_wr && (reg_addr == 12'(OFF_CMP0 + CMP_STRIDE*i + 8));
            cmp_rd_func[i]  = reg_rd && (reg_addr == 12'(OFF_CMP0 + CMP_STRIDE*i + 8));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    wm_cyc_ctr #(.W(CYC_W)) u_cyc (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (trace_en && ctrl_q.cyc_on),
        .wr_en  (cyc_wr),
        .wr_val (reg_wdata[CYC_W-1:0]),
        .cnt    (cyc_cnt)
    );

    for (genvar g = 0; g < NUM_EVT; g++) begin : g_evt
        wm_evt_ctr #(.W(EVT_W)) u_evt (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick   (trace_en && ev_in[g]),
            .wr_en  (evt_wr[g]),
            .wr_val (reg_wdata[EVT_W-1:0]),
            .cnt    (evt_cnt[g]),
            .ovf    (ovf_evt[g])
        );
    end

    for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
        wm_cmp #(.AW(AW), .MW(MASK_W)) u_cmp (
            .clk       (clk),
            .rst_n     (rst_n),
            .gate      (trace_en),
            .bus_valid (bus_valid),
            .bus_write (bus_write),
            .bus_addr  (bus_addr),
            .set_addr  (cmp_set_addr[g]),
            .set_mask  (cmp_set_mask[g]),
            .set_func  (cmp_set_func[g]),
            .wval_addr (reg_wdata[AW-1:0]),
            .wval_mask (reg_wdata[MASK_W-1:0]),
            .wval_func (reg_wdata[4:0]),
            .rd_func   (cmp_rd_func[g]),
            .addr_o    (cmp_addr[g]),
            .mask_o    (cmp_mask[g]),
            .kind_o    (cmp_kind[g]),
            .act_o     (cmp_act[g]),
            .sticky_o  (cmp_sticky[g]),
            .hit_halt  (cmp_halt[g]),
            .hit_evt   (cmp_evt[g])
        );
    end

    assign halt_req  = |cmp_halt;
    assign watch_evt = cmp_evt;

    // read mux
    always_comb begin
        logic [31:0] fw;
        reg_rdata = '0;
        fw        = '0;
        if (reg_addr == OFF_CTRL) reg_rdata = {31'b0, ctrl_q.cyc_on};
        if (reg_addr == OFF_CYC)  reg_rdata = 32'(cyc_cnt);
        if (reg_addr == OFF_PC)   reg_rdata = pc_in;
        for (int i = 0; i < NUM_EVT; i++)
            if (reg_addr == 12'(OFF_EVT0 + 4*i)) reg_rdata = 32'(evt_cnt[i]);
        if (32'(reg_addr) >= OFF_CMP0 && 32'(reg_addr) < CMP_END) begin
            for (int i = 0; i < NUM_CMP; i++) begin
                if (reg_addr == 12'(OFF_CMP0 + CMP_STRIDE*i))
                    reg_rdata = 32'(cmp_addr[i]);
                if (reg_addr == 12'(OFF_CMP0 + CMP_STRIDE*i + 4))
                    reg_rdata = 32'(cmp_mask[i]);
                if (reg_addr == 12'(OFF_CMP0 + CMP_STRIDE*i + 8)) begin
                    fw                = '0;
                    fw[3:0]           = cmp_kind[i];
                    fw[FN_ACT_BIT]    = cmp_act[i];
                    fw[FN_STICKY_BIT] = cmp_sticky[i];
                    reg_rdata         = fw;
                end
            end
        end
    end

    // R10
    halt_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt_req |-> (bus_valid && trace_en));
    // R10
    evt_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (watch_evt != '0) |-> (bus_valid && trace_en));
    // R2
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == OFF_CTRL) |=> $stable(ctrl_q.cyc_on));
endmodule

// File: tb/cycwatch_top_bench.sv
`timescale 1ns/1ps
module cycwatch_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trace_en = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] pc_in = '0;
    logic [4:0]  ev_in = '0;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [31:0] bus_addr = '0;
    logic        halt_req;
    logic [3:0]  watch_evt;
    logic [4:0]  ovf_evt;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    cycwatch_top u_cycwatch_top (
        .clk(clk), .rst_n(rst_n), .trace_en(trace_en),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pc_in(pc_in),
        .ev_in(ev_in), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .halt_req(halt_req), .watch_evt(watch_evt),
        .ovf_evt(ovf_evt)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(posedge clk); #1;
        reg_rd = 1'b0;
    endtask

    // gate open for exactly n rising edges
    task automatic pulse_gate(input int n);
        @(negedge clk);
        trace_en = 1'b1;
        repeat (n) @(negedge clk);
        trace_en = 1'b0;
    endtask

    // one bus access; returns combinational outputs in that cycle
    task automatic bus_probe(input bit wr, input logic [31:0] a,
                             output logic h, output logic [3:0] ev);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = wr; bus_addr = a;
        #1 h = halt_req; ev = watch_evt;
        @(posedge clk); #1;
        bus_valid = 1'b0;
    endtask

    function automatic bit ref_hit(input logic [31:0] ca, input int m, input int f,
                                   input bit wr, input logic [31:0] a);
        logic [31:0] care;
        bit kind;
        care = 32'hFFFF_FFFF << m;
        case (f)
            5: kind = !wr;
            6: kind = wr;
            7: kind = 1'b1;
            default: kind = 1'b0;
        endcase
        return kind && (((a ^ ca) & care) == 32'h0);
    endfunction

    function automatic logic [11:0] cmp_off(input int c, input int sub);
        return 12'(32 + 16*c + sub);
    endfunction

    initial begin
        logic [31:0] v, v2;
        logic h;
        logic [3:0] ev;
        logic [31:0] cfg_addr [4];
        int cfg_mask [4];
        int cfg_fn [4];
        bit cfg_act [4];
        bit exp_sticky [4];
        int kinds [5] = '{0, 3, 5, 6, 7};

        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        reg_read(12'h000, v); chk("R1 ctrl", v, 0);
        reg_read(12'h004, v); chk("R1 cyc", v, 0);
        for (int i = 0; i < 5; i++) begin
            reg_read(12'(8 + 4*i), v); chk("R1 evt", v, 0);
        end
        for (int c = 0; c < 4; c++) begin
            reg_read(cmp_off(c, 0), v); chk("R1 cmp addr", v, 0);
            reg_read(cmp_off(c, 8), v); chk("R1 cmp func", v, 0);
        end
        chk("R1 outputs", {22'b0, halt_req, watch_evt, ovf_evt}, 0);

        // R2 enable and random windows
        reg_write(12'h000, 32'h1);
        for (int t = 0; t < 6; t++) begin
            int n;
            v2 = $urandom;
            n = 1 + $urandom % 40;
            reg_write(12'h004, v2);
            pulse_gate(n);
            reg_read(12'h004, v); chk("R2 cyc window", v, v2 + 32'(n));
        end
        // R2 consecutive reads with gate held open
        @(negedge clk); trace_en = 1'b1;
        reg_read(12'h004, v);
        repeat (5) @(negedge clk);
        reg_read(12'h004, v2); chk("R2 cyc running", v2 - v, 32'd6);
        @(negedge clk); trace_en = 1'b0;
        // R2 control bit off: hold
        reg_write(12'h000, 32'h0);
        reg_read(12'h004, v);
        pulse_gate(7);
        reg_read(12'h004, v2); chk("R2 cyc disabled", v2, v);
        reg_read(12'h000, v); chk("R2 ctrl readback", v, 0);
        reg_write(12'h000, 32'h1);

        // R3 wrap
        reg_write(12'h004, 32'hFFFF_FFFE);
        pulse_gate(3);
        reg_read(12'h004, v); chk("R3 cyc wrap", v, 32'h1);

        // R12 gate low: no counting
        reg_write(12'h004, 32'h55);
        ev_in = 5'h1F;
        repeat (6) @(negedge clk);
        ev_in = 5'h0;
        reg_read(12'h004, v); chk("R12 cyc gated", v, 32'h55);

        // R4 event counters with random patterns
        for (int t = 0; t < 6; t++) begin
            logic [7:0] base [5];
            logic [4:0] pat;
            int n;
            for (int i = 0; i < 5; i++) begin
                base[i] = 8'($urandom);
                reg_write(12'(8 + 4*i), 32'(base[i]));
            end
            pat = 5'($urandom);
            n = 1 + $urandom % 30;
            ev_in = pat;
            pulse_gate(n);
            ev_in = '0;
            for (int i = 0; i < 5; i++) begin
                reg_read(12'(8 + 4*i), v);
                chk("R4 evt count", v, 32'(8'(base[i] + (pat[i] ? 8'(n) : 8'd0))));
            end
        end
        reg_read(12'h00C, v);
        ev_in = 5'h1F;
        repeat (4) @(negedge clk);
        ev_in = 5'h0;
        reg_read(12'h00C, v2); chk("R12 evt gated", v2, v);

        // R5 wrap and overflow pulse on counter 3
        reg_write(12'h014, 32'hFE);
        ev_in = 5'b01000;
        @(negedge clk); trace_en = 1'b1;
        @(negedge clk); chk("R5 no ovf at FF", 32'(ovf_evt), 0);
        @(negedge clk); trace_en = 1'b0;
        chk("R5 ovf pulse", 32'(ovf_evt), 32'b01000);
        @(negedge clk); chk("R5 ovf one cycle", 32'(ovf_evt), 0);
        ev_in = '0;
        reg_read(12'h014, v); chk("R5 evt wrapped", v, 0);

        // R6 program counter sample
        for (int t = 0; t < 3; t++) begin
            pc_in = $urandom;
            reg_read(12'h01C, v); chk("R6 pc sample", v, pc_in);
        end
        reg_write(12'h01C, 32'h1234);
        pc_in = 32'h0800_0400;
        reg_read(12'h01C, v); chk("R6 pc write ignored", v, 32'h0800_0400);

        // R7 register placement
        for (int c = 0; c < 4; c++) begin
            reg_write(cmp_off(c, 0), 32'hA000_0000 + 32'(c));
            reg_write(cmp_off(c, 4), 32'(c + 1));
        end
        for (int c = 0; c < 4; c++) begin
            reg_read(cmp_off(c, 0), v); chk("R7 addr slot", v, 32'hA000_0000 + 32'(c));
            reg_read(cmp_off(c, 4), v); chk("R7 mask slot", v, 32'(c + 1));
        end

        // R8/R9/R10 directed on comparator 0: 256-byte write watch, halting
        for (int c = 1; c < 4; c++) reg_write(cmp_off(c, 8), 32'h0);
        reg_write(cmp_off(0, 0), 32'h2000_0100);
        reg_write(cmp_off(0, 4), 32'd8);
        reg_write(cmp_off(0, 8), 32'd6);
        reg_read(cmp_off(0, 8), v);
        trace_en = 1'b1;
        bus_probe(1'b1, 32'h2000_01FC, h, ev); chk("R8 R10 in region halt", {31'b0, h}, 1);
        chk("R10 no event when halting", 32'(ev), 0);
        bus_probe(1'b1, 32'h2000_0200, h, ev); chk("R8 past region", {31'b0, h}, 0);
        bus_probe(1'b1, 32'h2000_00FF, h, ev); chk("R8 below region", {31'b0, h}, 0);
        bus_probe(1'b0, 32'h2000_0100, h, ev); chk("R9 read on write watch", {31'b0, h}, 0);
        // R11 sticky flag
        reg_read(cmp_off(0, 8), v); chk("R11 sticky set", v, 32'h0100_0006);
        reg_read(cmp_off(0, 8), v); chk("R11 sticky cleared", v, 32'h0000_0006);
        // R10 event action
        reg_write(cmp_off(0, 8), 32'h17);
        bus_probe(1'b0, 32'h2000_0180, h, ev);
        chk("R10 event no halt", {31'b0, h}, 0);
        chk("R10 event bit", 32'(ev), 32'h1);
        // R12 gate low blocks matching
        trace_en = 1'b0;
        reg_read(cmp_off(0, 8), v);
        bus_probe(1'b1, 32'h2000_0100, h, ev);
        chk("R12 no match gated", {27'b0, h, ev}, 0);
        reg_read(cmp_off(0, 8), v); chk("R12 no sticky gated", v, 32'h17);

        // Random comparator configurations and accesses
        trace_en = 1'b1;
        for (int round = 0; round < 8; round++) begin
            for (int c = 0; c < 4; c++) begin
                cfg_addr[c] = $urandom;
                cfg_mask[c] = $urandom % 13;
                cfg_fn[c]   = kinds[$urandom % 5];
                cfg_act[c]  = 1'($urandom);
                exp_sticky[c] = 1'b0;
                reg_write(cmp_off(c, 0), cfg_addr[c]);
                reg_write(cmp_off(c, 4), 32'(cfg_mask[c]));
                reg_write(cmp_off(c, 8), 32'(cfg_fn[c]) | (cfg_act[c] ? 32'h10 : 32'h0));
            end
            for (int c = 0; c < 4; c++) reg_read(cmp_off(c, 8), v);
            for (int k = 0; k < 25; k++) begin
                int c;
                bit wr;
                logic [31:0] a;
                bit exp_h;
                logic [3:0] exp_ev;
                c  = $urandom % 4;
                wr = 1'($urandom);
                a  = (($urandom % 4) == 0) ? $urandom : cfg_addr[c] ^ ($urandom % 8192);
                exp_h = 1'b0; exp_ev = '0;
                for (int j = 0; j < 4; j++) begin
                    if (ref_hit(cfg_addr[j], cfg_mask[j], cfg_fn[j], wr, a)) begin
                        exp_sticky[j] = 1'b1;
                        if (cfg_act[j]) exp_ev[j] = 1'b1;
                        else            exp_h = 1'b1;
                    end
                end
                bus_probe(wr, a, h, ev);
                chk("R8 R9 R10 random halt", {31'b0, h}, {31'b0, exp_h});
                chk("R8 R9 R10 random event", 32'(ev), 32'(exp_ev));
            end
            for (int c = 0; c < 4; c++) begin
                reg_read(cmp_off(c, 8), v);
                chk("R11 random sticky", v,
                    (exp_sticky[c] ? 32'h0100_0000 : 32'h0) | 32'(cfg_fn[c]) | (cfg_act[c] ? 32'h10 : 32'h0));
            end
        end
        trace_en = 1'b0;

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not complete");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule